// File: doc/BRIEF.md
# PWM Duty-Cycle Measurement Unit

This block turns an external pulse-width-modulated brightness pin into an 11-bit duty code. The pin passes through a two-flop synchroniser. Two counters run on a fast sample clock and are anchored to one chosen kind of edge. One counter holds the length of the last full period. The other holds how many of those ticks were at the active level. At every reference edge the finished pair goes to a sequential divider, which returns floor(active_ticks * 2047 / period_ticks). A hysteresis filter then decides whether the new code replaces the one on the output.

A long idle stretch after the last rising edge of the pin forces a result without waiting for another edge. A level that is held active reports full scale. A level that is held inactive reports zero, and the consumer treats zero as "backlight off". While `en` is low the unit stays idle and its output is zero, as it must be when brightness comes only from a register.

The result is a plain strobe stream with no back-pressure. `duty_valid` pulses for one cycle when `duty` takes a new value. `duty` then holds until the next pulse, so a consumer that misses the pulse can still read the current level. No new value is accepted while the divider is busy. A reference edge that arrives during a division only restarts the counters.

Top module: `pwm_duty_meter`

## Requirements
- R1: With `edge_sel`=0 the period runs from one rising edge of the synchronised pin to the next. With `edge_sel`=1 it runs from one falling edge to the next.
- R2: With `pol`=1 the ticks at high level are the active part of the period. With `pol`=0 the ticks at low level are.
- R3: For a period of P ticks with A active ticks, `duty` becomes floor(A*2047/P). `duty_valid` is high for exactly one cycle, registered at the 14th rising clock edge after the edge that first samples the pin level which closes the period.
- R4: After enable or after a timeout, the first reference edge only starts counting. The first result computed after that is passed to the output whatever the hysteresis setting, and it clears `timed_out`.
- R5: Any later result is passed only if it differs from the current `duty` by at least 1, 2, 4 or 8 codes, for `hyst` = 0, 1, 2 or 3. A smaller change leaves `duty` unchanged and raises no `duty_valid`.
- R6: When TIMEOUT_TICKS clock cycles pass after the last rising edge of the synchronised pin with no new rising edge, the unit emits `duty_valid`. The new `duty` is 2047 if the pin is at its active level and 0 if it is not. `timed_out` goes high and stays high until a result is passed.
- R7: After reset, and at every clock edge that samples `en` low, `duty`, `duty_valid` and `timed_out` are all 0 and the measurement restarts from scratch.
- R8: A timeout fires only once per idle stretch. Holding the pin after a timeout produces no further `duty_valid` until a rising edge occurs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock (nominally 24 MHz) |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Measurement enable; low holds the unit idle |
| pwm_in | input | 1 | Raw, asynchronous PWM pin |
| edge_sel | input | 1 | Period reference edge: 0 rising, 1 falling |
| pol | input | 1 | Active level: 1 high, 0 low |
| hyst | input | 2 | Hysteresis code, threshold 1 << hyst codes |
| duty | output | 11 | Measured duty code, 0 to 2047 |
| duty_valid | output | 1 | One-cycle strobe when `duty` takes a new value |
| timed_out | output | 1 | High after an idle timeout until the next passed result |

## Verification
The hardest case to reach from the ports is a result that arrives right after a timeout. It carries a small change that would normally be filtered, yet it must pass because the unit was disarmed. The stimulus holds the pin high long past the timeout, then holds it low with no rising edge. It then restarts with a 998/2 tick pattern whose code sits five codes below full scale, with the widest hysteresis selected. The bench model follows the synchronised pin through a delay queue, so every switch of reference edge or polarity between phases is checked cycle by cycle, including the odd transitional periods.

// File: rtl/pwm_meas_pkg.sv
package pwm_meas_pkg;
  localparam int DUTY_W = 11;
  localparam int DUTY_FULL = (1 << DUTY_W) - 1;
  localparam int HYST_W = 2;

  function automatic logic [DUTY_W-1:0] hyst_threshold(input logic [HYST_W-1:0] code);
    return DUTY_W'(1) << code;
  endfunction
endpackage

// File: rtl/pwm_in_sync.sv
module pwm_in_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin,
  output logic level,
  output logic rise,
  output logic fall
);
  logic [STAGES-1:0] stage;
  logic              last;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage <= '0;
      last  <= 1'b0;
    end else begin
      stage[0] <= pin;
      for (int i = 1; i < STAGES; i++) stage[i] <= stage[i-1];
      last <= stage[STAGES-1];
    end
  end

  assign level = stage[STAGES-1];
  assign rise  = level & ~last;
  assign fall  = ~level & last;
endmodule

// File: rtl/pwm_span_counter.sv
module pwm_span_counter #(
  parameter int TIMEOUT_TICKS = 576000,
  parameter int CNT_W = 21
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             level,
  input  logic             rise,
  input  logic             fall,
  input  logic             edge_sel,
  input  logic             pol,
  input  logic             div_busy,
  output logic             start,
  output logic [CNT_W-1:0] on_snap,
  output logic [CNT_W-1:0] per_snap,
  output logic             timeout,
  output logic             active
);
  localparam int IDLE_W = $clog2(TIMEOUT_TICKS + 1);
  localparam logic [IDLE_W-1:0] IDLE_LAST = IDLE_W'(TIMEOUT_TICKS - 1);
  localparam logic [IDLE_W-1:0] IDLE_SAT  = IDLE_W'(TIMEOUT_TICKS);

  logic [CNT_W-1:0]  per_cnt, on_cnt;
  logic [IDLE_W-1:0] idle_cnt;
  logic              armed, ref_edge;

  assign active   = pol ? level : ~level;
  assign ref_edge = en & (edge_sel ? fall : rise);
  assign timeout  = en & ~rise & (idle_cnt == IDLE_LAST);
  assign start    = ref_edge & armed & ~div_busy & ~timeout;
  assign on_snap  = on_cnt;
  assign per_snap = per_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      per_cnt  <= '0;
      on_cnt   <= '0;
      idle_cnt <= '0;
      armed    <= 1'b0;
    end else if (!en) begin
      per_cnt  <= '0;
      on_cnt   <= '0;
      idle_cnt <= '0;
      armed    <= 1'b0;
    end else begin
      if (rise) idle_cnt <= '0;
      else if (idle_cnt != IDLE_SAT) idle_cnt <= idle_cnt + IDLE_W'(1);
      if (ref_edge) begin
        per_cnt <= CNT_W'(1);
        on_cnt  <= CNT_W'(active);
        armed   <= ~timeout;
      end else begin
        if (per_cnt != '1) per_cnt <= per_cnt + CNT_W'(1);
        on_cnt <= on_cnt + CNT_W'(active);
        armed  <= armed & ~timeout;
      end
    end
  end
endmodule

// File: rtl/duty_divider.sv
module duty_divider #(
  parameter int CNT_W = 21,
  parameter int Q_W = 11
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             flush,
  input  logic             start,
  input  logic [CNT_W-1:0] on_cnt,
  input  logic [CNT_W-1:0] per_cnt,
  output logic             busy,
  output logic             done,
  output logic [Q_W-1:0]   quot
);
  localparam int NUM_W = CNT_W + Q_W;
  localparam int IDX_W = $clog2(Q_W);
  localparam logic [NUM_W-1:0] SCALE = NUM_W'((1 << Q_W) - 1);

  logic [NUM_W-1:0] rem, den_sh;
  logic [CNT_W-1:0] den;
  logic [IDX_W-1:0] bit_idx;

  assign den_sh = NUM_W'(den) << bit_idx;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rem <= '0; den <= '0; bit_idx <= '0; quot <= '0;
      busy <= 1'b0; done <= 1'b0;
    end else if (flush) begin
      busy <= 1'b0; done <= 1'b0;
    end else begin
      done <= 1'b0;
      if (start && !busy) begin
        rem     <= NUM_W'(on_cnt) * SCALE;
        den     <= per_cnt;
        bit_idx <= IDX_W'(Q_W - 1);
        quot    <= '0;
        busy    <= 1'b1;
      end else if (busy) begin
        if (rem >= den_sh) begin
          rem           <= rem - den_sh;
          quot[bit_idx] <= 1'b1;
        end
        if (bit_idx == '0) begin
          busy <= 1'b0;
          done <= 1'b1;
        end else begin
          bit_idx <= bit_idx - IDX_W'(1);
        end
      end
    end
  end
endmodule

// File: rtl/duty_hyst_filter.sv
module duty_hyst_filter
  import pwm_meas_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              done,
  input  logic [DUTY_W-1:0] quot,
  input  logic [HYST_W-1:0] hyst,
  input  logic              timeout,
  input  logic              active,
  output logic [DUTY_W-1:0] duty,
  output logic              duty_valid,
  output logic              timed_out
);
  logic              first;
  logic [DUTY_W-1:0] diff;
  logic              pass;

  always_comb begin
    diff = (quot >= duty) ? (quot - duty) : (duty - quot);
    pass = first | (diff >= hyst_threshold(hyst));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      duty <= '0; duty_valid <= 1'b0; timed_out <= 1'b0; first <= 1'b1;
    end else if (!en) begin
      duty <= '0; duty_valid <= 1'b0; timed_out <= 1'b0; first <= 1'b1;
    end else begin
      duty_valid <= 1'b0;
      if (timeout) begin
        duty       <= active ? '1 : '0;
        duty_valid <= 1'b1;
        timed_out  <= 1'b1;
        first      <= 1'b1;
      end else if (done && pass) begin
        duty       <= quot;
        duty_valid <= 1'b1;
        timed_out  <= 1'b0;
        first      <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/pwm_duty_meter.sv
module pwm_duty_meter
  import pwm_meas_pkg::*;
#(
  parameter int TIMEOUT_TICKS = 576000,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              pwm_in,
  input  logic              edge_sel,
  input  logic              pol,
  input  logic [HYST_W-1:0] hyst,
  output logic [DUTY_W-1:0] duty,
  output logic              duty_valid,
  output logic              timed_out
);
  localparam int CNT_W = $clog2(2 * TIMEOUT_TICKS + 2);

  logic             level, rise, fall;
  logic             start, timeout, active, busy, done;
  logic [CNT_W-1:0] on_snap, per_snap;
  logic [DUTY_W-1:0] quot;

  pwm_in_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .pin(pwm_in),
    .level(level), .rise(rise), .fall(fall)
  );

  pwm_span_counter #(.TIMEOUT_TICKS(TIMEOUT_TICKS), .CNT_W(CNT_W)) u_span (
    .clk(clk), .rst_n(rst_n), .en(en), .level(level), .rise(rise), .fall(fall),
    .edge_sel(edge_sel), .pol(pol), .div_busy(busy), .start(start),
    .on_snap(on_snap), .per_snap(per_snap), .timeout(timeout), .active(active)
  );

  duty_divider #(.CNT_W(CNT_W), .Q_W(DUTY_W)) u_div (
    .clk(clk), .rst_n(rst_n), .flush(~en | timeout), .start(start),
    .on_cnt(on_snap), .per_cnt(per_snap), .busy(busy), .done(done), .quot(quot)
  );

  duty_hyst_filter u_filt (
    .clk(clk), .rst_n(rst_n), .en(en), .done(done), .quot(quot), .hyst(hyst),
    .timeout(timeout), .active(active), .duty(duty), .duty_valid(duty_valid),
    .timed_out(timed_out)
  );
endmodule

// File: rtl/pwm_duty_meter_checker.sv
module pwm_duty_meter_checker (
  input logic        clk,
  input logic        rst_n,
  input logic        en,
  input logic [10:0] duty,
  input logic        duty_valid,
  input logic        timed_out
);
  // R7: a strobe can only come from a clock edge that sampled en high
  assert_valid_needs_enable_R7: assert property (@(posedge clk) disable iff (!rst_n)
    duty_valid |-> $past(en));

  // R7: an edge that sampled en low leaves every output cleared
  assert_disabled_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(en) |-> (duty == 11'd0) && !duty_valid && !timed_out);

  // R5: the output code only moves together with a strobe
  assert_hold_without_valid_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(en) && !duty_valid) |-> (duty == $past(duty)));

  // R6: a timeout reports one of the two extremes, with a strobe
  assert_timeout_extreme_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(timed_out) |-> duty_valid && ((duty == 11'd0) || (duty == 11'd2047)));

  // R4: timed_out is only cleared by a passed result or by disable
  assert_timeout_sticky_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(en) && $past(timed_out) && !duty_valid) |-> timed_out);
endmodule

bind pwm_duty_meter pwm_duty_meter_checker u_chk (
  .clk(clk), .rst_n(rst_n), .en(en), .duty(duty),
  .duty_valid(duty_valid), .timed_out(timed_out)
);

// File: tb/pwm_duty_meter_bench.sv
`timescale 1ns/1ps
module pwm_duty_meter_bench;
  localparam int TO = 3000;
  localparam int FULL = 2047;
  localparam int MAX_CYC = 150000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        en = 1'b0, pwm = 1'b0, edge_sel = 1'b0, pol = 1'b1;
  logic [1:0]  hyst = 2'd0;
  logic [10:0] duty;
  logic        duty_valid, timed_out;

  int    checks = 0, errors = 0, vcount = 0;
  bit    done = 1'b0;
  string tag = "R7";

  always #4 clk = ~clk;

  pwm_duty_meter #(.TIMEOUT_TICKS(TO)) u_pwm_duty_meter (
    .clk(clk), .rst_n(rst_n), .en(en), .pwm_in(pwm), .edge_sel(edge_sel),
    .pol(pol), .hyst(hyst), .duty(duty), .duty_valid(duty_valid), .timed_out(timed_out)
  );

  // ---------------- behavioural reference model ----------------
  int cyc = 0, last_rise = 0, last_start = -100, per_m = 0, on_m = 0;
  bit armed_m = 0, first_m = 1, m_valid = 0, m_to = 0;
  int m_duty = 0;
  int hist[$] = '{0, 0, 0};
  int due_q[$];
  int val_q[$];

  always @(posedge clk) begin
    int d, dp, act, q, diff;
    bit rise, fall, refe, tmo;
    cyc++;
    if (!rst_n) begin
      hist = '{0, 0, 0};
      due_q.delete(); val_q.delete();
      m_duty = 0; m_valid = 0; m_to = 0; first_m = 1; armed_m = 0;
      per_m = 0; on_m = 0; last_rise = cyc; last_start = -100;
    end else begin
      hist.push_back(int'(pwm));
      if (hist.size() > 8) void'(hist.pop_front());
      d  = hist[hist.size()-3];
      dp = hist[hist.size()-4];
      rise = (d == 1) && (dp == 0);
      fall = (d == 0) && (dp == 1);
      act  = pol ? d : 1 - d;
      if (!en) begin
        due_q.delete(); val_q.delete();
        m_duty = 0; m_valid = 0; m_to = 0; first_m = 1; armed_m = 0;
        per_m = 0; on_m = 0; last_rise = cyc; last_start = -100;
      end else begin
        refe = edge_sel ? fall : rise;
        tmo  = !rise && (cyc - last_rise == TO);
        if (rise) last_rise = cyc;
        m_valid = 0;
        if (tmo) begin
          m_duty = act ? FULL : 0; m_valid = 1; m_to = 1; first_m = 1;
          due_q.delete(); val_q.delete(); last_start = -100;
        end else if (due_q.size() > 0 && due_q[0] == cyc) begin
          q = val_q[0];
          void'(due_q.pop_front()); void'(val_q.pop_front());
          diff = (q > m_duty) ? q - m_duty : m_duty - q;
          if (first_m || diff >= (1 << hyst)) begin
            m_duty = q; m_valid = 1; m_to = 0; first_m = 0;
          end
        end
        if (refe) begin
          if (armed_m && !tmo && cyc >= last_start + 12) begin
            due_q.push_back(cyc + 12);
            val_q.push_back((on_m * FULL) / per_m);
            last_start = cyc;
          end
          armed_m = !tmo; per_m = 1; on_m = act;
        end else begin
          per_m++; on_m += act; armed_m = armed_m && !tmo;
        end
      end
    end
  end

  // per-cycle comparison away from the active edge
  always @(negedge clk) begin
    checks++;
    if (duty !== 11'(m_duty) || duty_valid !== m_valid || timed_out !== m_to) begin
      errors++;
      $display("FAIL %s per-cycle @%0d actual duty=%0d valid=%0b to=%0b expected duty=%0d valid=%0b to=%0b",
               tag, cyc, duty, duty_valid, timed_out, m_duty, m_valid, m_to);
    end
    if (duty_valid === 1'b1) vcount++;
  end

  task automatic check_eq(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic drive(input int hi, input int lo, input int n);
    for (int i = 0; i < n; i++) begin
      pwm = 1'b1; repeat (hi) @(negedge clk);
      pwm = 1'b0; repeat (lo) @(negedge clk);
    end
  endtask

  task automatic hold(input logic lvl, input int n);
    pwm = lvl; repeat (n) @(negedge clk);
  endtask

  initial begin
    int vsnap;
    repeat (4) @(negedge clk);
    check_eq("R7 reset duty", int'(duty), 0);
    check_eq("R7 reset strobe", int'(duty_valid), 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    en = 1'b1;

    tag = "R3"; drive(300, 700, 4);
    check_eq("R3 30pct", int'(duty), (300 * FULL) / 1000);
    drive(500, 500, 3);
    check_eq("R3 50pct", int'(duty), (500 * FULL) / 1000);
    drive(40, 60, 6);
    check_eq("R3 short period", int'(duty), (40 * FULL) / 100);

    tag = "R1"; edge_sel = 1'b1; drive(250, 750, 3);
    check_eq("R1 falling reference", int'(duty), (250 * FULL) / 1000);

    tag = "R2"; pol = 1'b0; drive(250, 750, 3);
    check_eq("R2 low active", int'(duty), (750 * FULL) / 1000);

    tag = "R5"; pol = 1'b1; edge_sel = 1'b0; hyst = 2'd2;
    drive(500, 500, 3);
    check_eq("R5 base", int'(duty), (500 * FULL) / 1000);
    vsnap = vcount;
    drive(501, 499, 3);
    check_eq("R5 small change held", int'(duty), (500 * FULL) / 1000);
    check_eq("R5 no strobe", vcount - vsnap, 0);
    drive(503, 497, 3);
    check_eq("R5 large change passed", int'(duty), (503 * FULL) / 1000);

    tag = "R6"; hold(1'b1, TO + 100);
    check_eq("R6 high timeout duty", int'(duty), FULL);
    check_eq("R6 timed_out set", int'(timed_out), 1);
    tag = "R8"; vsnap = vcount;
    hold(1'b0, TO + 100);
    check_eq("R8 single timeout", vcount - vsnap, 0);
    check_eq("R8 duty kept", int'(duty), FULL);

    tag = "R4"; hyst = 2'd3;
    drive(998, 2, 4);
    check_eq("R4 first result passes", int'(duty), (998 * FULL) / 1000);
    check_eq("R4 timed_out cleared", int'(timed_out), 0);

    tag = "R6"; hold(1'b0, TO + 100);
    check_eq("R6 low timeout duty", int'(duty), 0);
    check_eq("R6 low timed_out", int'(timed_out), 1);

    tag = "R7"; hyst = 2'd0;
    drive(300, 700, 2);
    en = 1'b0;
    repeat (20) @(negedge clk);
    check_eq("R7 disabled duty", int'(duty), 0);
    check_eq("R7 disabled timed_out", int'(timed_out), 0);
    vsnap = vcount;
    drive(300, 700, 2);
    check_eq("R7 no strobe while disabled", vcount - vsnap, 0);
    en = 1'b1;
    drive(300, 700, 3);
    check_eq("R7 restart", int'(duty), (300 * FULL) / 1000);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (MAX_CYC) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=expired expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule